// File: doc/BRIEF.md
# Port Pin Pull-Up and Open-Drain Control

This block controls six general-purpose port pins. It holds two 6-bit settings, a weak pull-up request per pin and an open-drain request per pin. Software reaches both through a small 8-bit register bus. From these settings and a set of status flags, the block produces three per-pin enables that the pad ring consumes: pull-up on, PMOS driver on and NMOS driver on. The flags are the operating mode, the direction bits, the serial-peripheral ownership flags and the address-output enable field.

First the block decides whether each pin is an input or an output. In the external-bus modes, an address-output enable makes a pin an output and takes priority. Otherwise, a serial peripheral that owns the pin sets its direction. If neither applies, the direction bit decides. In the single-chip mode (mode 7) the address-output field is ignored.

A pull-up request only takes effect on an input pin. An open-drain request turns a non-address output into an NMOS-only driver: it pulls low for a 0 and leaves the pin floating for a 1. Both settings clear on reset and on hardware standby. They hold their contents during software standby.

Top module: `portctl_pullod`

## Requirements
- R1: In both registers, bits 5..0 control pins 5..0. Writes to bits 7..6 have no effect, and reads return 1 in bits 7..6.
- R2: `bus_sel`=0 selects the pull-up register and `bus_sel`=1 selects the open-drain register. A write with `bus_wr`=1 shows up on the clock edge that samples it. `bus_rdata` follows the selected register combinationally.
- R3: `pu_en[i]` is 1 exactly when pull-up bit i is 1 and pin i is an input.
- R4: When `op_mode` is not 7, a pin is an output in either of two cases: its address-output bit is set (pins 0..3 only, `addr_en[i]`), or the first of the following that applies makes it one. If `sio_own[i]`=1, `sio_out[i]` gives the direction. Otherwise `dir_out[i]` gives it (1 means output).
- R5: When `op_mode` is 7, `addr_en` has no effect. Direction comes from `sio_own`/`sio_out`, or otherwise from `dir_out`.
- R6: On an output pin that is not an address output and has its open-drain bit set, `pmos_en` is 0 and `nmos_en` is the inverse of `pin_dout`. With data 1, both enables are 0.
- R7: On an output pin whose open-drain bit is clear, or that is an address output, `pmos_en`=`pin_dout` and `nmos_en`=~`pin_dout`.
- R8: On an input pin, `pmos_en` and `nmos_en` are both 0.
- R9: Pins 5 and 4 have no address-output control. Their open-drain bit applies whenever they are outputs, in every mode.
- R10: An active-low `rst_n` clears both registers asynchronously. `hw_stby`=1 clears them on the next clock edge, ahead of any write.
- R11: While `sw_stby`=1 and `hw_stby`=0, writes are ignored and both registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby entry; clears the registers |
| sw_stby | input | 1 | Software standby; registers hold |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = pull-up register, 1 = open-drain register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| op_mode | input | 3 | Operating mode |
| dir_out | input | 6 | Direction bits, 1 = output |
| sio_own | input | 6 | Serial peripheral owns the pin |
| sio_out | input | 6 | Serial peripheral drives the pin as output |
| addr_en | input | 4 | Address-output enables for pins 3..0 |
| pin_dout | input | 6 | Output data per pin |
| pu_en | output | 6 | Pull-up enable per pin |
| pmos_en | output | 6 | PMOS driver enable per pin |
| nmos_en | output | 6 | NMOS driver enable per pin |

## Verification
The hardest case to reach is an address-enabled pin that also carries open-drain and pull-up bits, seen in both mode 7 and an external-bus mode. Here the same register contents must give opposite results depending on the mode alone. Directed steps load both registers with all ones and then toggle only `op_mode` against fixed `addr_en`, `sio_own` and `dir_out` settings. Random vectors, with standby pulses mixed in sparingly, then check that the registers survive software standby while writes are offered and are wiped by hardware standby.

// File: rtl/portctl_pkg.sv
package portctl_pkg;
    localparam int NPIN   = 6;
    localparam int NADDR  = 4;
    localparam int DW     = 8;
    localparam int MODEW  = 3;
    localparam logic [MODEW-1:0] MODE_SINGLE = 3'd7;

    typedef struct packed {
        logic [NPIN-1:0] pu;
        logic [NPIN-1:0] od;
    } ctl_regs_t;
endpackage

// File: rtl/portctl_regs.sv
module portctl_regs
    import portctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_stby,
    input  logic            sw_stby,
    input  logic            wr,
    input  logic            sel,
    input  logic [NPIN-1:0] wdata,
    output logic [NPIN-1:0] pu_q,
    output logic [NPIN-1:0] od_q
);
    ctl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (hw_stby) begin
            regs_d = '0;
        end else if (wr && !sw_stby) begin
            if (sel) regs_d.od = wdata;
            else     regs_d.pu = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pu_q = regs_q.pu;
    assign od_q = regs_q.od;

    AST_HWSTBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pu_q == '0 && od_q == '0)); // R10
    AST_SWSTBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> ($stable(pu_q) && $stable(od_q))); // R11
endmodule

// File: rtl/portctl_pinmode.sv
module portctl_pinmode
    import portctl_pkg::*;
(
    input  logic [MODEW-1:0] mode,
    input  logic [NPIN-1:0]  dir_out,
    input  logic [NPIN-1:0]  sio_own,
    input  logic [NPIN-1:0]  sio_out,
    input  logic [NADDR-1:0] addr_en,
    output logic [NPIN-1:0]  is_input,
    output logic [NPIN-1:0]  is_addr
);
    logic ext_bus;
    assign ext_bus = (mode != MODE_SINGLE);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic own_out;
        assign own_out = sio_own[i] ? sio_out[i] : dir_out[i];
        if (i < NADDR) begin : g_addr
            assign is_addr[i] = ext_bus && addr_en[i];
        end else begin : g_noaddr
            assign is_addr[i] = 1'b0;
        end
        assign is_input[i] = !(is_addr[i] || own_out);
    end
endmodule

// File: rtl/portctl_drive.sv
module portctl_drive
    import portctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] is_input,
    input  logic [NPIN-1:0] is_addr,
    input  logic [NPIN-1:0] pu_q,
    input  logic [NPIN-1:0] od_q,
    input  logic [NPIN-1:0] dout,
    output logic [NPIN-1:0] pu_en,
    output logic [NPIN-1:0] pmos_en,
    output logic [NPIN-1:0] nmos_en
);
    for (genvar i = 0; i < NPIN; i++) begin : g_drv
        logic od_act;
        always_comb begin
            od_act     = od_q[i] && !is_addr[i];
            pu_en[i]   = pu_q[i] && is_input[i];
            pmos_en[i] = 1'b0;
            nmos_en[i] = 1'b0;
            if (!is_input[i]) begin
                nmos_en[i] = !dout[i];
                pmos_en[i] = od_act ? 1'b0 : dout[i];
            end
        end
    end

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        (pmos_en & nmos_en) == '0); // R7
    AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pmos_en | nmos_en) & is_input) == '0); // R8
    AST_PU_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_en & ~is_input) == '0); // R3
endmodule

// File: rtl/portctl_pullod.sv
module portctl_pullod
    import portctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic             bus_wr,
    input  logic             bus_sel,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [MODEW-1:0] op_mode,
    input  logic [NPIN-1:0]  dir_out,
    input  logic [NPIN-1:0]  sio_own,
    input  logic [NPIN-1:0]  sio_out,
    input  logic [NADDR-1:0] addr_en,
    input  logic [NPIN-1:0]  pin_dout,
    output logic [NPIN-1:0]  pu_en,
    output logic [NPIN-1:0]  pmos_en,
    output logic [NPIN-1:0]  nmos_en
);
    localparam int RSVW = DW - NPIN;

    logic [NPIN-1:0] pu_q, od_q, is_input, is_addr;
    logic [RSVW-1:0] rsv_unused;
    assign rsv_unused = bus_wdata[DW-1:NPIN];

    portctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .wr(bus_wr), .sel(bus_sel), .wdata(bus_wdata[NPIN-1:0]),
        .pu_q(pu_q), .od_q(od_q)
    );

    portctl_pinmode u_mode (
        .mode(op_mode), .dir_out(dir_out), .sio_own(sio_own),
        .sio_out(sio_out), .addr_en(addr_en),
        .is_input(is_input), .is_addr(is_addr)
    );

    portctl_drive u_drv (
        .clk(clk), .rst_n(rst_n), .is_input(is_input), .is_addr(is_addr),
        .pu_q(pu_q), .od_q(od_q), .dout(pin_dout),
        .pu_en(pu_en), .pmos_en(pmos_en), .nmos_en(nmos_en)
    );

    assign bus_rdata = {{RSVW{1'b1}}, (bus_sel ? od_q : pu_q)};

    AST_RSV_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:NPIN] == {RSVW{1'b1}}); // R1
endmodule

// File: tb/portctl_pullod_test.sv
module portctl_pullod_test;
    logic clk = 0, rst_n = 0, hw_stby = 0, sw_stby = 0, bus_wr = 0, bus_sel = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [2:0] op_mode = 3'd4;
    logic [5:0] dir_out = 0, sio_own = 0, sio_out = 0, pin_dout = 0;
    logic [3:0] addr_en = 0;
    logic [5:0] pu_en, pmos_en, nmos_en;
    logic [5:0] pu_m = 0, od_m = 0;
    int nchk = 0, nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    portctl_pullod uut (.*);

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic is_ao(int i);
        return (i < 4) && (op_mode != 3'd7) && addr_en[i];
    endfunction
    function automatic logic [5:0] exp_in();
        logic [5:0] r;
        for (int i = 0; i < 6; i++)
            r[i] = !(is_ao(i) || (sio_own[i] ? sio_out[i] : dir_out[i]));
        return r;
    endfunction
    function automatic logic [5:0] exp_pmos();
        logic [5:0] r, inp;
        inp = exp_in();
        for (int i = 0; i < 6; i++)
            r[i] = !inp[i] && !(od_m[i] && !is_ao(i)) && pin_dout[i];
        return r;
    endfunction
    function automatic logic [5:0] exp_nmos();
        return ~exp_in() & ~pin_dout;
    endfunction

    // at negedge with inputs settled: compare all outputs
    task automatic check_all(string tag);
        #1;
        chk({tag, " R3 pull-up"}, {2'b0, pu_en}, {2'b0, pu_m & exp_in()});
        chk({tag, " R6/R7/R8 pmos"}, {2'b0, pmos_en}, {2'b0, exp_pmos()});
        chk({tag, " R6/R7/R8 nmos"}, {2'b0, nmos_en}, {2'b0, exp_nmos()});
        chk({tag, " R1/R2 read"}, bus_rdata, {2'b11, bus_sel ? od_m : pu_m});
    endtask

    task automatic tick();
        @(posedge clk);
        if (hw_stby) begin pu_m = 0; od_m = 0; end
        else if (bus_wr && !sw_stby) begin
            if (bus_sel) od_m = bus_wdata[5:0]; else pu_m = bus_wdata[5:0];
        end
        @(negedge clk);
        bus_wr = 0; hw_stby = 0; sw_stby = 0;
    endtask

    task automatic wr(logic s, logic [7:0] d);
        bus_wr = 1; bus_sel = s; bus_wdata = d; tick();
    endtask

    initial begin
        #100000000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (2) @(negedge clk);
        bus_sel = 0; check_all("R10 reset pu");
        bus_sel = 1; check_all("R10 reset od");
        rst_n = 1;
        @(negedge clk);

        // R1 reserved bits / R2 mapping
        wr(0, 8'h3f); bus_sel = 0; check_all("R1 write 3f pu");
        wr(1, 8'hc0); bus_sel = 1; check_all("R1 reserved only od");
        chk("R1 od after c0", bus_rdata, 8'hc0);

        // R4 vs R5: address enabled pin with pull-up and open-drain set
        wr(1, 8'hff);
        chk("R2 od all ones", bus_rdata, 8'hff);
        dir_out = 6'h00; sio_own = 0; addr_en = 4'hf; pin_dout = 6'h3f;
        op_mode = 3'd5; check_all("R4 ext mode addr out");
        chk("R4 addr pins push-pull", {2'b0, pmos_en}, 8'h0f);
        chk("R4 addr pins no pull-up", {2'b0, pu_en}, 8'h30);
        op_mode = 3'd7; check_all("R5 single mode");
        chk("R5 addr_en ignored", {2'b0, pu_en}, 8'h3f);

        // R6 open-drain data 1 floats; R9 pins 5/4
        dir_out = 6'h3f; pin_dout = 6'h30; addr_en = 0; op_mode = 3'd4;
        check_all("R9 pins 5/4 open drain");
        chk("R6 float high", {2'b0, pmos_en | nmos_en}, 8'h0f);
        // sio override
        sio_own = 6'h03; sio_out = 6'h01; dir_out = 6'h00;
        check_all("R4 sio override");

        // R11 software standby holds
        bus_sel = 0; bus_wr = 1; bus_wdata = 8'h00; sw_stby = 1; tick();
        check_all("R11 sw standby hold");
        chk("R11 pu kept", bus_rdata, 8'hff);
        // R10 hw standby beats write
        bus_wr = 1; bus_wdata = 8'h2a; hw_stby = 1; tick();
        check_all("R10 hw standby clear");
        chk("R10 pu zero", bus_rdata, 8'hc0);

        for (int n = 0; n < 3000; n++) begin
            op_mode  = ($urandom % 4 == 0) ? 3'd7 : 3'(4 + $urandom % 3);
            dir_out  = 6'($urandom); sio_own = 6'($urandom); sio_out = 6'($urandom);
            addr_en  = 4'($urandom); pin_dout = 6'($urandom);
            bus_wr   = ($urandom % 3 == 0); bus_sel = 1'($urandom);
            bus_wdata = 8'($urandom);
            sw_stby  = ($urandom % 8 == 0); hw_stby = ($urandom % 40 == 0);
            check_all("rand");
            tick();
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule